// File: doc/BRIEF.md
# Pointer Address Self-Test Sequencer

This block is a manufacturing self-test engine for the pointer-address path of a SONET/SDH receiver. It steps two counters against each other. One is a payload-envelope position counter, which advances on every test clock. The other is a pointer generator that produces the J1 pointer value; each pointer value p stands for envelope position 3·p.

A test has two sweeps:
- **Decrement sweep.** The position counter advances every clock and the pointer steps down once every third clock. Nothing is compared in this sweep.
- **Increment sweep.** The pointer's envelope address is compared with the position counter on every clock. The pointer advances only on a match, so a healthy path matches on every third clock. The match bit is compacted into a 16-bit signature register.

Because the pointer advances only on a match, one missed match leaves the two counters out of step. That changes the final signature.

When the increment sweep has run its full length, the done flag rises and all counting stops. The tester then asserts the shift enable and clocks the signature out serially, most significant bit first. The scan path is a plain serial shift with no flow control: every clock with shift enable high moves exactly one bit, and the tester always accepts it.

Top module: `ptr_addr_selftest`

## Requirements
- R1: While test_en is low, all state is cleared on the next clock: position 0, pointer 0, divider 0, signature 0, sweep count 0. In that state done and scan_out are 0. An active-low asynchronous rst_n gives the same state.
- R2: In a running decrement clock (test_en=1, scan_shift=0, inc_mode=0, done=0), the position counter advances modulo 3·NUM_PTR and the signature does not change.
- R3: In decrement mode the pointer steps down on every third running clock, and 0 wraps to NUM_PTR-1. After 3·NUM_PTR running decrement clocks from a cleared start, the pointer and the position are both back at 0.
- R4: In a running increment clock (inc_mode=1), a match is declared when the position equals 3·pointer. The pointer steps up on a match (NUM_PTR-1 wraps to 0) and holds otherwise. The position advances on every such clock.
- R5: On every running increment clock the signature takes in the match bit. The update is: feedback = sig[15] XOR match, then sig = (sig<<1) XOR (feedback ? 16'h1021 : 0).
- R6: done rises after exactly 3·NUM_PTR running increment clocks since the last clear. While done is high, no counter and no signature bit changes except through scan shifting.
- R7: While test_en=1 and scan_shift=1, scan_out shows sig[15]. On each clock the signature shifts left with scan_in entering bit 0, and the counters and the sweep count hold.
- R8: If the increment sweep starts with the pointer not aligned to the position, the pointer holds until a match happens. The resulting signature differs from the aligned one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Test enable; low clears the engine |
| inc_mode | input | 1 | 1 = increment sweep, 0 = decrement sweep |
| scan_shift | input | 1 | Shift the signature instead of counting |
| scan_in | input | 1 | Serial bit shifted into signature bit 0 |
| scan_out | output | 1 | Signature bit 15 |
| done | output | 1 | Increment sweep complete |

## Verification
The bench builds the block with NUM_PTR = 12, which makes a full sweep 36 clocks. This brings every wrap within reach in a short run: pointer 0 to 11 going down, 11 to 0 going up, and the position wrapping at 36. It also lets the bench repeat whole sweeps several times. The bench covers an aligned sweep, a misaligned sweep entered after only part of the decrement sweep, scan shifting in the middle of a sweep with a nonzero input pattern, and clocks after done. A behavioural model checks scan_out and done on every clock.

// File: rtl/pas_pkg.sv
package pas_pkg;
  localparam int unsigned SIG_W = 16;
  typedef logic [SIG_W-1:0] sig_t;

  function automatic sig_t sig_step(sig_t s, logic din, sig_t poly);
    logic fb;
    fb = s[SIG_W-1] ^ din;
    return {s[SIG_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/pas_position_ctr.sv
module pas_position_ctr #(
  parameter int unsigned LEN = 2349,
  localparam int unsigned PW = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] pos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (clr)    pos <= '0;
    else if (adv)    pos <= (pos == PW'(LEN - 1)) ? '0 : pos + 1'b1;
  end

  a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pos) < LEN);
  a_r2_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && adv && pos == PW'(LEN - 1)) |=> pos == '0);
endmodule

// File: rtl/pas_pointer_gen.sv
module pas_pointer_gen #(
  parameter int unsigned NUM_PTR = 783,
  parameter int unsigned STEP    = 3,
  localparam int unsigned AW = $clog2(NUM_PTR),
  localparam int unsigned TW = $clog2(STEP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          dec_en,
  input  logic          inc_en,
  output logic [AW-1:0] ptr
);
  logic [TW-1:0] tick;
  logic          dec_fire;

  assign dec_fire = dec_en && (tick == TW'(STEP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tick <= '0;
    else if (clr)    tick <= '0;
    else if (dec_en) tick <= dec_fire ? '0 : tick + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (clr)      ptr <= '0;
    else if (dec_fire) ptr <= (ptr == '0) ? AW'(NUM_PTR - 1) : ptr - 1'b1;
    else if (inc_en)   ptr <= (ptr == AW'(NUM_PTR - 1)) ? '0 : ptr + 1'b1;
  end

  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) < NUM_PTR);
  a_r3_dec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && dec_fire && ptr == '0) |=> ptr == AW'(NUM_PTR - 1));
  a_r3_no_dual_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_en && inc_en));
endmodule

// File: rtl/pas_signature.sv
module pas_signature
  import pas_pkg::*;
#(
  parameter sig_t POLY = 16'h1021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic din,
  input  logic shift,
  input  logic sin,
  output sig_t sig
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clr)   sig <= '0;
    else if (shift) sig <= {sig[SIG_W-2:0], sin};
    else if (upd)   sig <= sig_step(sig, din, POLY);
  end

  a_r7_shift_path: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && shift) |=> sig[0] == $past(sin) && sig[SIG_W-1:1] == $past(sig[SIG_W-2:0]));
endmodule

// File: rtl/ptr_addr_selftest.sv
module ptr_addr_selftest
  import pas_pkg::*;
#(
  parameter int unsigned NUM_PTR = 783,
  parameter int unsigned STEP    = 3,
  parameter sig_t        POLY    = 16'h1021,
  localparam int unsigned LEN = NUM_PTR * STEP,
  localparam int unsigned PW  = $clog2(LEN),
  localparam int unsigned AW  = $clog2(NUM_PTR),
  localparam int unsigned CW  = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_en,
  input  logic inc_mode,
  input  logic scan_shift,
  input  logic scan_in,
  output logic scan_out,
  output logic done
);
  logic          clr, run, run_inc, run_dec, hit;
  logic [PW-1:0] pos, addr;
  logic [AW-1:0] ptr;
  logic [CW-1:0] sweep_cnt;
  sig_t          sig;

  assign clr     = !test_en;
  assign run     = test_en && !scan_shift && !done;
  assign run_inc = run && inc_mode;
  assign run_dec = run && !inc_mode;
  assign addr    = PW'(32'(ptr) * STEP);
  assign hit     = run_inc && (pos == addr);

  pas_position_ctr #(.LEN(LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(run), .pos(pos)
  );

  pas_pointer_gen #(.NUM_PTR(NUM_PTR), .STEP(STEP)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .dec_en(run_dec), .inc_en(hit), .ptr(ptr)
  );

  pas_signature #(.POLY(POLY)) u_sig (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(run_inc), .din(hit),
    .shift(test_en && scan_shift), .sin(scan_in), .sig(sig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sweep_cnt <= '0;
    else if (clr)     sweep_cnt <= '0;
    else if (run_inc) sweep_cnt <= sweep_cnt + 1'b1;
  end

  assign done     = (sweep_cnt == CW'(LEN));
  assign scan_out = sig[SIG_W-1];

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> (sig == '0 && !done && pos == '0 && ptr == '0));
  a_r2_sig_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    run_dec |=> $stable(sig));
  a_r4_hold_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (run_inc && pos != addr) |=> $stable(ptr));
  a_r6_done_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && !scan_shift && done) |=> (done && $stable(sig) && $stable(pos) && $stable(ptr)));
  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && scan_shift) |=> ($stable(pos) && $stable(ptr) && $stable(done)));
endmodule

// File: tb/ptr_addr_selftest_bench.sv
module ptr_addr_selftest_bench;
  localparam int N   = 12;
  localparam int LEN = 3 * N;

  logic clk = 0, rst_n = 0;
  logic test_en = 0, inc_mode = 0, scan_shift = 0, scan_in = 0;
  logic scan_out, done;

  int checks = 0, fails = 0, cycles = 0;
  int m_pos, m_ptr, m_tick, m_cnt;
  logic [15:0] m_sig, sig_aligned;

  always #10 clk = ~clk;

  ptr_addr_selftest #(.NUM_PTR(N)) u_ptr_addr_selftest (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .inc_mode(inc_mode),
    .scan_shift(scan_shift), .scan_in(scan_in), .scan_out(scan_out), .done(done)
  );

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_pos = 0; m_ptr = 0; m_tick = 0; m_cnt = 0; m_sig = 16'h0;
  endtask

  task automatic model_step(logic te, logic inc, logic sh, logic si);
    logic m, fb;
    if (!te) model_clear();
    else if (sh) m_sig = {m_sig[14:0], si};
    else if (m_cnt != LEN) begin
      if (!inc) begin
        if (m_tick == 2) begin
          m_tick = 0;
          m_ptr = (m_ptr == 0) ? N - 1 : m_ptr - 1;
        end else m_tick++;
      end else begin
        m = (m_pos == 3 * m_ptr);
        fb = m_sig[15] ^ m;
        m_sig = {m_sig[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
        if (m) m_ptr = (m_ptr + 1) % N;
        m_cnt++;
      end
      m_pos = (m_pos + 1) % LEN;
    end
  endtask

  task automatic cyc(string req, logic te, logic inc, logic sh, logic si);
    @(negedge clk);
    test_en = te; inc_mode = inc; scan_shift = sh; scan_in = si;
    @(posedge clk);
    model_step(te, inc, sh, si);
    #5;
    check(req, done, (m_cnt == LEN), "done");
    check(req, scan_out, m_sig[15], "scan_out");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #5;
    check("R1", done, 1'b0, "done in reset");
    check("R1", scan_out, 1'b0, "scan_out in reset");
    @(negedge clk); rst_n = 1;
    cyc("R1", 0, 0, 0, 0);

    // Aligned test: full decrement sweep, then increment sweep
    for (int i = 0; i < LEN; i++) cyc("R3", 1, 0, 0, 0);
    check("R2", (m_sig == 16'h0) ? 1'b1 : 1'b0, 1'b1, "model sig quiet");
    for (int i = 0; i < LEN; i++) cyc("R4", 1, 1, 0, 0);
    check("R6", done, 1'b1, "done at sweep end");
    sig_aligned = m_sig;
    for (int i = 0; i < 5; i++) cyc("R6", 1, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R6", 1, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc("R5", 1, 1, 1, 0);
    cyc("R1", 0, 0, 0, 0);
    check("R1", done, 1'b0, "done after clear");

    // Decrement sweep then shift out: signature must still read zero
    for (int i = 0; i < LEN; i++) cyc("R2", 1, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc("R2", 1, 0, 1, 0);
    cyc("R1", 0, 0, 0, 0);

    // Misaligned: partial decrement sweep
    for (int i = 0; i < 4; i++) cyc("R8", 1, 0, 0, 0);
    for (int i = 0; i < LEN; i++) cyc("R8", 1, 1, 0, 0);
    check("R8", (m_sig != sig_aligned) ? 1'b1 : 1'b0, 1'b1, "model sig differs");
    for (int i = 0; i < 16; i++) cyc("R8", 1, 1, 1, 0);
    cyc("R1", 0, 0, 0, 0);

    // Shift with a pattern mid-sweep; counting resumes after
    for (int i = 0; i < LEN; i++) cyc("R3", 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) cyc("R4", 1, 1, 0, 0);
    for (int i = 0; i < 7; i++) cyc("R7", 1, 1, 1, logic'(i % 2));
    for (int i = 0; i < LEN - 10; i++) cyc("R6", 1, 1, 0, 0);
    check("R6", done, 1'b1, "done after shift pause");
    for (int i = 0; i < 16; i++) cyc("R7", 1, 1, 1, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule